// File: doc/BRIEF.md
# Binary-Weight Convolution Engine

This block produces one output pixel of a two-dimensional convolution. Each request carries a square window of signed 12-bit fixed-point activations, up to 7×7 of them, together with one weight bit per tap. Every filter weight is either +1 or -1. Each tap therefore passes either its activation or the two's-complement negation of it, and no multiplier is involved until the final scaling step. A run-time kernel size selects the active k×k corner of the window, and every other tap contributes zero. The signed sum is then multiplied by a per-output-channel scale factor, rounded, offset by a per-channel bias and clamped back to 12 bits.

Windows enter on a valid/ready stream, one per cycle, and results leave on a valid/ready stream with a fixed three-stage latency. Back-pressure is global. While `out_valid` is high and `out_ready` is low, every stage holds, `in_ready` is low, and `out_data` does not change. An input beat is taken only on a cycle where both `in_valid` and `in_ready` are high. An output beat is consumed only on a cycle where both `out_valid` and `out_ready` are high. The scale and bias tables are plain static inputs that the surrounding logic keeps steady while results are in flight.

Top module: `bwconv_engine`

## Requirements
- R1: Tap t sits at row t/7 and column t%7. Its activation is bits [12t+11:12t] of `in_window` and its weight is bit t of `in_wbits`. A weight bit of 1 adds the activation and a weight bit of 0 subtracts it.
- R2: `in_ksize` gives the kernel edge k, from 1 to 7, and the value 0 is treated as 1. Taps with row ≥ k or column ≥ k add zero, whatever their activation or weight bit.
- R3: The sum of up to 49 signed terms is exact for all inputs, including 49 taps of -2048 each. The sum does not wrap.
- R4: `in_chan` selects the output channel c. The scale factor is the signed Q2.10 word `scale_cfg[12c+11:12c]` and the bias is the signed word `bias_cfg[12c+11:12c]`, in activation units.
- R5: The result is floor((sum·scale + 512) / 1024) + bias, so halves round toward +infinity.
- R6: The result is clamped to the range [-2048, 2047] before it is driven on `out_data`.
- R7: With `out_ready` held high, the engine accepts one window every cycle. A window accepted at clock edge N appears on the outputs just after edge N+2.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold and `in_ready` is low. Every accepted window yields exactly one result, in order.
- R9: During reset and on the first cycle after it, `out_valid` is low. `in_ready` is high during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window beat offered |
| in_ready | output | 1 | Engine can take a window this cycle |
| in_window | input | 588 | 49 signed 12-bit activations, tap t at bits [12t+11:12t] |
| in_wbits | input | 49 | One weight bit per tap: 1 gives +1, 0 gives -1 |
| in_ksize | input | 3 | Kernel edge length, 1 to 7 (0 is treated as 1) |
| in_chan | input | 2 | Output channel of this window |
| scale_cfg | input | 48 | Four signed Q2.10 scale factors |
| bias_cfg | input | 48 | Four signed 12-bit biases |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 12 | Scaled, biased, saturated result |

## Verification
On every cycle the assertions check the stream rules. A stalled output keeps its valid and data and blocks the input. A window accepted three cycles back with no stall in between must be on the output. Reset leaves the output idle. The arithmetic cannot be checked that way. Sign selection, tap masking for each kernel size, exact wide sums, rounding of halves in both directions, saturation at both ends and channel selection are shown only by the bench's scenarios. Those scenarios compare every result against an integer-multiply model, under random traffic and random output stalls.

// File: rtl/bwconv_pkg.sv
package bwconv_pkg;
  localparam int ACT_W_DEF = 12;
  localparam int KMAX_DEF  = 7;
  localparam int SC_W_DEF  = 12;
  localparam int FRAC_DEF  = 10;

  // bits needed for an exact sum of 'taps' negated-or-not activations
  function automatic int acc_width(input int aw, input int taps);
    return aw + 1 + $clog2(taps);
  endfunction
endpackage

// File: rtl/bwconv_sign_stage.sv
module bwconv_sign_stage #(
  parameter int ACT_W = 12,
  parameter int KMAX  = 7,
  parameter int KSZ_W = 3,
  localparam int NTAP = KMAX * KMAX,
  localparam int TW   = ACT_W + 1
) (
  input  logic                  clk,
  input  logic                  en,
  input  logic [NTAP*ACT_W-1:0] window,
  input  logic [NTAP-1:0]       wbits,
  input  logic [KSZ_W-1:0]      ksize,
  output logic [NTAP*TW-1:0]    terms
);
  localparam logic [KSZ_W-1:0] KMAX_V = KSZ_W'(KMAX);

  logic [KSZ_W-1:0] keff;

  always_comb begin
    if (ksize == '0)         keff = KSZ_W'(1);
    else if (ksize > KMAX_V) keff = KMAX_V;
    else                     keff = ksize;
  end

  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    localparam logic [KSZ_W-1:0] ROW = KSZ_W'(t / KMAX);
    localparam logic [KSZ_W-1:0] COL = KSZ_W'(t % KMAX);
    logic signed [TW-1:0] ext;
    logic signed [TW-1:0] term;
    logic signed [TW-1:0] q;
    logic                 live;

    assign ext  = {window[t*ACT_W+ACT_W-1], window[t*ACT_W +: ACT_W]};
    assign live = (ROW < keff) && (COL < keff);
    assign term = !live ? '0 : (wbits[t] ? ext : -ext);

    always_ff @(posedge clk) begin
      if (en) q <= term;
    end

    assign terms[t*TW +: TW] = q;
  end
endmodule

// File: rtl/bwconv_sum_stage.sv
module bwconv_sum_stage #(
  parameter int NTAP  = 49,
  parameter int TW    = 13,
  parameter int ACC_W = 19
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic [NTAP*TW-1:0]      terms,
  output logic signed [ACC_W-1:0] sum
);
  logic signed [ACC_W-1:0] acc;

  // reduction over all taps; synthesis balances it into an adder tree
  always_comb begin
    acc = '0;
    for (int t = 0; t < NTAP; t++) begin
      logic signed [TW-1:0] tv;
      tv  = terms[t*TW +: TW];
      acc = acc + ACC_W'(tv);
    end
  end

  always_ff @(posedge clk) begin
    if (en) sum <= acc;
  end
endmodule

// File: rtl/bwconv_scale_stage.sv
module bwconv_scale_stage #(
  parameter int ACC_W = 19,
  parameter int SC_W  = 12,
  parameter int FRAC  = 10,
  parameter int OUT_W = 12,
  localparam int PW   = ACC_W + SC_W
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] sum,
  input  logic signed [SC_W-1:0]  scale,
  input  logic signed [OUT_W-1:0] bias,
  output logic signed [OUT_W-1:0] y
);
  localparam logic signed [PW:0] HALF = (PW+1)'(1) <<< (FRAC - 1);
  localparam logic signed [PW:0] MAXV = (PW+1)'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [PW:0] MINV = -MAXV - (PW+1)'(1);

  logic signed [PW-1:0] prod;
  logic signed [PW:0]   shifted;
  logic signed [PW:0]   total;
  logic signed [OUT_W-1:0] clamped;

  always_comb begin
    prod    = PW'(sum) * PW'(scale);
    shifted = ((PW+1)'(prod) + HALF) >>> FRAC;
    total   = shifted + (PW+1)'(bias);
    if (total > MAXV)      clamped = MAXV[OUT_W-1:0];
    else if (total < MINV) clamped = MINV[OUT_W-1:0];
    else                   clamped = total[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (en) y <= clamped;
  end
endmodule

// File: rtl/bwconv_engine.sv
module bwconv_engine import bwconv_pkg::*; #(
  parameter int ACT_W   = ACT_W_DEF,
  parameter int KMAX    = KMAX_DEF,
  parameter int NCH     = 4,
  parameter int SC_W    = SC_W_DEF,
  parameter int SC_FRAC = FRAC_DEF,
  localparam int NTAP  = KMAX * KMAX,
  localparam int TW    = ACT_W + 1,
  localparam int ACC_W = acc_width(ACT_W, NTAP),
  localparam int KSZ_W = $clog2(KMAX + 1),
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [NTAP*ACT_W-1:0] in_window,
  input  logic [NTAP-1:0]       in_wbits,
  input  logic [KSZ_W-1:0]      in_ksize,
  input  logic [CH_W-1:0]       in_chan,
  input  logic [NCH*SC_W-1:0]   scale_cfg,
  input  logic [NCH*ACT_W-1:0]  bias_cfg,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [ACT_W-1:0]      out_data
);
  logic                    adv;
  logic [2:0]              vld;
  logic [CH_W-1:0]         ch_s1, ch_s2;
  logic [NTAP*TW-1:0]      terms;
  logic signed [ACC_W-1:0] sum;
  logic signed [SC_W-1:0]  scale_sel;
  logic signed [ACT_W-1:0] bias_sel;
  logic signed [ACT_W-1:0] result;

  // one enable for the whole pipe: move unless the last stage is blocked
  assign adv      = !vld[2] || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (adv) begin
      vld <= {vld[1:0], in_valid};
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      ch_s1 <= in_chan;
      ch_s2 <= ch_s1;
    end
  end

  bwconv_sign_stage #(.ACT_W(ACT_W), .KMAX(KMAX), .KSZ_W(KSZ_W)) u_sign (
    .clk(clk), .en(adv), .window(in_window), .wbits(in_wbits),
    .ksize(in_ksize), .terms(terms)
  );

  bwconv_sum_stage #(.NTAP(NTAP), .TW(TW), .ACC_W(ACC_W)) u_sum (
    .clk(clk), .en(adv), .terms(terms), .sum(sum)
  );

  assign scale_sel = scale_cfg[ch_s2*SC_W +: SC_W];
  assign bias_sel  = bias_cfg[ch_s2*ACT_W +: ACT_W];

  bwconv_scale_stage #(.ACC_W(ACC_W), .SC_W(SC_W), .FRAC(SC_FRAC), .OUT_W(ACT_W)) u_scale (
    .clk(clk), .en(adv), .sum(sum), .scale(scale_sel), .bias(bias_sel), .y(result)
  );

  assign out_valid = vld[2];
  assign out_data  = result;
endmodule

// File: rtl/bwconv_chk.sv
module bwconv_chk #(
  parameter int ACT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ACT_W-1:0] out_data
);
  AST_STALL_HOLDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);  // R8
  AST_STALL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data));  // R8
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);  // R8
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 3) && $past(in_valid && in_ready, 3) && $past(in_ready, 2) && $past(in_ready)
    |-> out_valid);  // R7
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid);  // R9
endmodule

bind bwconv_engine bwconv_chk #(.ACT_W(ACT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/tb_bwconv_engine.sv
module tb_bwconv_engine;
  localparam int NT = 49;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [NT*AW-1:0] in_window = '0;
  logic [NT-1:0] in_wbits = '0;
  logic [2:0] in_ksize = 3'd1;
  logic [1:0] in_chan = '0;
  logic [47:0] scale_cfg = '0;
  logic [47:0] bias_cfg = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [AW-1:0] out_data;

  int nchk = 0, nfail = 0, cyc = 0;
  bit stall_mode = 0;
  longint exp_q[$];
  string  req_q[$];
  int     cyc_q[$];
  bit     lat_q[$];

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  bwconv_engine dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_window(in_window), .in_wbits(in_wbits), .in_ksize(in_ksize),
    .in_chan(in_chan), .scale_cfg(scale_cfg), .bias_cfg(bias_cfg),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint model(input logic [NT*AW-1:0] w, input logic [NT-1:0] b,
                                   input int k, input int ch);
    longint s = 0;
    longint p;
    int ke = (k == 0) ? 1 : k;
    for (int r = 0; r < ke; r++) begin
      for (int c = 0; c < ke; c++) begin
        longint a;
        a = longint'($signed(w[(r*7+c)*AW +: AW]));
        s += a * (b[r*7+c] ? 64'sd1 : -64'sd1);
      end
    end
    p = s * longint'($signed(scale_cfg[ch*12 +: 12]));
    p = (p + 512) >>> 10;
    p += longint'($signed(bias_cfg[ch*12 +: 12]));
    if (p > 2047) p = 2047;
    if (p < -2048) p = -2048;
    return p;
  endfunction

  // driver: offer one window, record the expectation when it is taken
  task automatic send(input string req, input logic [NT*AW-1:0] w, input logic [NT-1:0] b,
                      input int k, input int ch);
    @(negedge clk);
    in_window = w; in_wbits = b; in_ksize = 3'(k); in_chan = 2'(ch); in_valid = 1'b1;
    #5;
    while (!in_ready) begin
      @(negedge clk);
      #5;
    end
    exp_q.push_back(model(w, b, k, ch));
    req_q.push_back(req);
    cyc_q.push_back(cyc);
    lat_q.push_back(!stall_mode);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [NT*AW-1:0] fill(input logic [AW-1:0] v);
    logic [NT*AW-1:0] r;
    for (int t = 0; t < NT; t++) r[t*AW +: AW] = v;
    return r;
  endfunction

  function automatic logic [NT*AW-1:0] rand_win();
    logic [NT*AW-1:0] r;
    for (int t = 0; t < NT; t++) r[t*AW +: AW] = AW'($urandom);
    return r;
  endfunction

  // monitor: scoreboard compare, stall hold check, random back-pressure
  initial begin
    bit pend = 0;
    logic [AW-1:0] held = '0;
    forever begin
      @(negedge clk);
      out_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
      #5;
      if (!rst_n) continue;
      if (pend) begin
        check("R8 stalled valid held", longint'(out_valid), 1);
        check("R8 stalled data held", longint'(out_data), longint'(held));
        pend = 0;
      end
      if (out_valid) begin
        if (out_ready) begin
          if (exp_q.size() == 0) begin
            check("R8 unexpected output", 1, 0);
          end else begin
            string rq;
            bit lt;
            int c0;
            rq = req_q.pop_front();
            lt = lat_q.pop_front();
            c0 = cyc_q.pop_front();
            check(rq, longint'($signed(out_data)), exp_q.pop_front());
            if (lt) check("R7 latency", longint'(cyc - c0), 3);
          end
        end else begin
          held = out_data;
          pend = 1;
        end
      end
    end
  end

  initial begin
    #3000000;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [NT*AW-1:0] w;
    // channel 0: scale 1.0, bias 0; ch1: scale 1/1024; ch2: scale 0.5; ch3: scale -2.0, bias 100
    scale_cfg = {12'h800, 12'd512, 12'd1, 12'd1024};
    bias_cfg  = {12'd100, 12'd0, 12'd0, 12'd0};
    repeat (3) @(negedge clk);
    check("R9 out_valid in reset", longint'(out_valid), 0);
    check("R9 in_ready in reset", longint'(in_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    #5 check("R9 out_valid after reset", longint'(out_valid), 0);

    // R1 sign selection on a single tap
    w = fill(12'd0); w[0 +: AW] = 12'd300;
    send("R1 plus weight", w, '1, 1, 0);
    send("R1 minus weight", w, '0, 1, 0);
    w[0 +: AW] = 12'hF38;  // -200
    send("R1 negative act minus", w, '0, 1, 0);
    // R2 masking: garbage outside 3x3, and ksize 0 acts as 1
    w = fill(12'd1000);
    for (int r = 0; r < 3; r++) for (int c = 0; c < 3; c++) w[(r*7+c)*AW +: AW] = 12'd5;
    send("R2 k3 masks outer taps", w, '1, 3, 0);
    send("R2 ksize0 as 1", w, '1, 0, 0);
    send("R2 k7 all taps", fill(12'd7), 49'h0F0F0F0F0F0F, 7, 0);
    // R3 wide exact sums at 1/1024 scale, R6 clamping at 1.0
    send("R3 sum +100352", fill(12'h800), '0, 7, 1);
    send("R3 sum -100352", fill(12'h800), '1, 7, 1);
    send("R6 clamp high", fill(12'h800), '0, 7, 0);
    send("R6 clamp low", fill(12'h800), '1, 7, 0);
    // R5 rounding of halves at scale 0.5
    w = fill(12'd0); w[0 +: AW] = 12'd3;
    send("R5 +1.5 rounds up", w, '1, 1, 2);
    send("R5 -1.5 rounds up", w, '0, 1, 2);
    // R4 channel selection with negative scale and bias
    w[0 +: AW] = 12'd40;
    send("R4 ch3 scale bias", w, '1, 1, 3);
    send("R4 ch0 same window", w, '1, 1, 0);
    drain();

    // R7 back-to-back random traffic, then R8 with random back-pressure
    for (int i = 0; i < 60; i++)
      send("R7 random stream", rand_win(), {$urandom, $urandom}, $urandom_range(0, 7), $urandom_range(0, 3));
    drain();
    stall_mode = 1;
    for (int ph = 0; ph < 4; ph++) begin
      scale_cfg = {$urandom, $urandom};
      bias_cfg  = {$urandom, $urandom};
      for (int i = 0; i < 80; i++)
        send("R8 random under stall", rand_win(), {$urandom, $urandom}, $urandom_range(0, 7), $urandom_range(0, 3));
      drain();
    end
    stall_mode = 0;
    drain();
    check("R8 nothing lost", longint'(exp_q.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule